// File: doc/BRIEF.md
# Sleep/Wake Power-State Controller

This block runs in an always-on clock domain and moves a processor between three power states: Sleep, Energise and Active. A sleep request from the core, an external wake level and a core-supply-good flag come in asynchronously. Each passes through a two-flop synchroniser before the state machine acts on it. In Sleep the controller drives the supply-gate output low to switch the core supply off. In every other state the gate output is released (drive-enable low). An internal countdown delays the release of core reset after the supply comes back.

The controller settles the case where a sleep request and a wake pulse arrive together. The machine enters Sleep and leaves it again on the next clock, so the wake is never lost. A wake that is seen on the very clock that enters Sleep is also held in a one-cycle flag.

All outputs are registered from the next-state value, so core reset and the gate enable cannot glitch while the state changes.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller enters Energise with the countdown reloaded to `DELAY`. The outputs are then `core_rst_n`=0, `delay_run`=1 and `gate_drive_en`=0.
- R2: `sleep_in`, `wake_in` and `supply_good_in` each pass through two flops. A change set up before edge p can change the state no earlier than edge p+2.
- R3: In Active with supply good, a synchronised sleep request moves the controller to Sleep on the next edge.
- R4: In Sleep, a synchronised wake on any cycle moves the controller to Energise on the next edge. A wake and a sleep request that arrive together end in Sleep for one cycle, then Energise, then Active.
- R5: On entry to Energise the countdown holds `DELAY` and drops by one per cycle. The controller moves to Active on the edge after the countdown reaches zero while supply good is high. Energise therefore lasts `DELAY`+1 cycles when the supply is good throughout.
- R6: `core_rst_n` is 0 in Sleep and Energise and 1 only in Active.
- R7: `gate_drive_en` is 1 with `gate_level`=0 only in Sleep. In Energise and Active, `gate_drive_en`=0 and `gate_level`=1.
- R8: `delay_run` is 1 only in Energise.
- R9: If synchronised supply good is low in Active, the controller returns to Energise on the next edge, even when a sleep request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_in | input | 1 | Asynchronous sleep request from the core domain |
| wake_in | input | 1 | Asynchronous external wake level |
| supply_good_in | input | 1 | Asynchronous core-supply-good flag |
| gate_level | output | 1 | Value on the supply gate: 0 means supply off |
| gate_drive_en | output | 1 | 1 drives `gate_level`; 0 leaves the gate high impedance |
| delay_run | output | 1 | High while the power-up countdown runs |
| core_rst_n | output | 1 | Active-low core reset |

## Verification
The assertions assume that each asynchronous input holds a level for at least two controller clocks. Under that assumption, a wake seen as the machine enters Sleep is still visible, or still held, on the next edge. They also assume that `DELAY` is at least 2, so supply good has reached the state machine before the countdown expires after reset.

The stimulus keeps every random input level for two to six cycles. Directed sequences set up the coincident sleep and wake, supply loss during a sleep request, and the exact Energise length. Expected outputs come from a cycle model in the bench that is built from R2 to R9.

// File: rtl/pwrseq_pkg.sv
// Shared state type and synchroniser bit positions for the power sequencer.
// Assumes a three-state machine; encoding is not relied on outside this block.
package pwrseq_pkg;
    typedef enum logic [1:0] {
        PS_SLEEP    = 2'b00,
        PS_ENERGISE = 2'b01,
        PS_ACTIVE   = 2'b10
    } pwr_state_e;

    localparam int SYNC_W   = 3;
    localparam int IDX_SLP  = 0;
    localparam int IDX_WAKE = 1;
    localparam int IDX_GOOD = 2;
endpackage

// File: rtl/pwrseq_sync.sv
// Multi-bit bank of flop chains bringing asynchronous levels into clk.
// Assumes each bit is an independent level; no coherency between bits.
module pwrseq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // shift every input bit one stage per clock, clearing on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwrseq_delay.sv
// Loadable down-counter that times the Energise phase.
// Assumes load has priority over run; the counter stops at zero.
module pwrseq_delay #(
    parameter int DELAY = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    output logic          zero,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] RELOAD = CW'(DELAY);

    // reload outside Energise, count down inside it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= RELOAD;
        end else if (load) begin
            count <= RELOAD;
        end else if (run && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/pwrseq_fsm.sv
// Three-state power sequencer: Sleep, Energise, Active.
// Assumes synchronised inputs; holds a wake seen on the Active-to-Sleep
// edge for one cycle so that a coincident wake is never dropped.
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_sleep,
    input  logic       s_wake,
    input  logic       s_good,
    input  logic       cnt_zero,
    output pwr_state_e state_q,
    output pwr_state_e state_d,
    output logic       wake_held
);
    logic enter_sleep;

    // next-state selection; supply loss outranks a sleep request
    always_comb begin
        state_d     = state_q;
        enter_sleep = 1'b0;
        unique case (state_q)
            PS_ACTIVE: begin
                if (!s_good) begin
                    state_d = PS_ENERGISE;
                end else if (s_sleep) begin
                    state_d     = PS_SLEEP;
                    enter_sleep = 1'b1;
                end
            end
            PS_SLEEP: begin
                if (s_wake || wake_held) begin
                    state_d = PS_ENERGISE;
                end
            end
            PS_ENERGISE: begin
                if (cnt_zero && s_good) begin
                    state_d = PS_ACTIVE;
                end
            end
            default: state_d = PS_ENERGISE;
        endcase
    end

    // state register, reset lands in Energise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_ENERGISE;
        end else begin
            state_q <= state_d;
        end
    end

    // remember a wake that coincides with the move into Sleep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_held <= 1'b0;
        end else begin
            wake_held <= enter_sleep && s_wake;
        end
    end
endmodule

// File: rtl/pwrseq_outdec.sv
// Registered output decode taken from the next state, so the outputs
// change on the same edge as the state without decode glitches.
// Assumes reset state is Energise.
module pwrseq_outdec
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state_d,
    output logic       gate_level,
    output logic       gate_drive_en,
    output logic       delay_run,
    output logic       core_rst_n
);
    // register every output from the state about to be entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_level    <= 1'b1;
            gate_drive_en <= 1'b0;
            delay_run     <= 1'b1;
            core_rst_n    <= 1'b0;
        end else begin
            gate_level    <= (state_d != PS_SLEEP);
            gate_drive_en <= (state_d == PS_SLEEP);
            delay_run     <= (state_d == PS_ENERGISE);
            core_rst_n    <= (state_d == PS_ACTIVE);
        end
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Top of the sleep/wake power sequencer in the always-on domain.
// Assumes asynchronous input levels last at least two clocks.
module pwr_seq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int DELAY       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_in,
    input  logic wake_in,
    input  logic supply_good_in,
    output logic gate_level,
    output logic gate_drive_en,
    output logic delay_run,
    output logic core_rst_n
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn;
    logic              cnt_zero;
    logic [CW-1:0]     cnt;
    logic              wake_held;
    pwr_state_e        state_q;
    pwr_state_e        state_d;

    assign raw_in[IDX_SLP]  = sleep_in;
    assign raw_in[IDX_WAKE] = wake_in;
    assign raw_in[IDX_GOOD] = supply_good_in;

    pwrseq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    pwrseq_delay #(.DELAY(DELAY), .CW(CW)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q != PS_ENERGISE),
        .run   (state_q == PS_ENERGISE),
        .zero  (cnt_zero),
        .count (cnt)
    );

    pwrseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_sleep   (syn[IDX_SLP]),
        .s_wake    (syn[IDX_WAKE]),
        .s_good    (syn[IDX_GOOD]),
        .cnt_zero  (cnt_zero),
        .state_q   (state_q),
        .state_d   (state_d),
        .wake_held (wake_held)
    );

    pwrseq_outdec u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_d       (state_d),
        .gate_level    (gate_level),
        .gate_drive_en (gate_drive_en),
        .delay_run     (delay_run),
        .core_rst_n    (core_rst_n)
    );
endmodule

// File: rtl/pwr_seq_chk.sv
// Property checker for pwr_seq_ctrl, attached with bind below.
module pwr_seq_chk
    import pwrseq_pkg::*;
#(
    parameter int DELAY = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input pwr_state_e    state,
    input logic [CW-1:0] count,
    input logic          s_sleep,
    input logic          s_wake,
    input logic          s_good,
    input logic          wake_held,
    input logic          gate_level,
    input logic          gate_drive_en,
    input logic          delay_run,
    input logic          core_rst_n
);
    // R1
    reset_enter_chk: assert property (@(posedge clk)
        !rst_n |=> (state == PS_ENERGISE && count == CW'(DELAY)));
    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && s_good && s_sleep) |=> state == PS_SLEEP);
    // R4
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SLEEP && (s_wake || wake_held)) |=> state == PS_ENERGISE);
    // R4
    race_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && s_good && s_sleep && s_wake) |=> (state == PS_SLEEP && wake_held));
    // R5
    hold_energise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ENERGISE && count != '0) |=> state == PS_ENERGISE);
    // R9
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && !s_good) |=> state == PS_ENERGISE);
    // R6
    release_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n |-> state == PS_ACTIVE);
    // R8
    run_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delay_run) |-> count == CW'(DELAY));
    // R7
    gate_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_drive_en |-> (state == PS_SLEEP && !gate_level));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.DELAY(DELAY), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .count         (cnt),
    .s_sleep       (syn[IDX_SLP]),
    .s_wake        (syn[IDX_WAKE]),
    .s_good        (syn[IDX_GOOD]),
    .wake_held     (wake_held),
    .gate_level    (gate_level),
    .gate_drive_en (gate_drive_en),
    .delay_run     (delay_run),
    .core_rst_n    (core_rst_n)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int D = 6;
    localparam int ST_S = 0, ST_E = 1, ST_A = 2;

    logic clk = 1'b0;
    logic rst_n, sleep_i, wake_i, good_i;
    logic gate_level, gate_drive_en, delay_run, core_rst_n;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_ctrl #(.DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_in(sleep_i), .wake_in(wake_i),
        .supply_good_in(good_i), .gate_level(gate_level),
        .gate_drive_en(gate_drive_en), .delay_run(delay_run),
        .core_rst_n(core_rst_n)
    );

    // cycle model built from the requirements (R2..R9)
    int m_st, m_cnt;
    logic [2:0] m_s1, m_s2;   // {good, wake, sleep}
    logic m_wh;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= ST_E; m_cnt <= D; m_s1 <= '0; m_s2 <= '0; m_wh <= 1'b0;
        end else begin
            m_s1 <= {good_i, wake_i, sleep_i};
            m_s2 <= m_s1;
            m_cnt <= (m_st != ST_E) ? D : ((m_cnt != 0) ? m_cnt - 1 : 0);
            m_wh <= (m_st == ST_A) && m_s2[2] && m_s2[0] && m_s2[1];
            case (m_st)
                ST_A: if (!m_s2[2]) m_st <= ST_E; else if (m_s2[0]) m_st <= ST_S;
                ST_S: if (m_s2[1] || m_wh) m_st <= ST_E;
                default: if (m_cnt == 0 && m_s2[2]) m_st <= ST_A;
            endcase
        end
    end

    function automatic logic exp_rst(int st);  return st == ST_A; endfunction
    function automatic logic exp_oe(int st);   return st == ST_S; endfunction
    function automatic logic exp_run(int st);  return st == ST_E; endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    bit cmp_on = 0;
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R6 core_rst_n", core_rst_n, exp_rst(m_st));
            chk("R7 gate_drive_en", gate_drive_en, exp_oe(m_st));
            chk("R7 gate_level", gate_level, !exp_oe(m_st));
            chk("R8 delay_run", delay_run, exp_run(m_st));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 0; sleep_i = 0; wake_i = 0; good_i = 1;
        repeat (3) @(negedge clk);
        chk("R1 core_rst_n", core_rst_n, 1'b0);
        chk("R1 delay_run", delay_run, 1'b1);
        chk("R1 gate_drive_en", gate_drive_en, 1'b0);
        cmp_on = 1;
        rst_n = 1;
        repeat (D) @(negedge clk);
        chk("R5 still energise", core_rst_n, 1'b0);
        @(negedge clk);
        chk("R5 active after DELAY+1", core_rst_n, 1'b1);

        // R2/R3: sleep latency
        sleep_i = 1;
        repeat (2) @(negedge clk);
        chk("R2 not yet sleeping", core_rst_n, 1'b1);
        @(negedge clk);
        chk("R3 in sleep", gate_drive_en, 1'b1);
        sleep_i = 0;

        // R4: wake from sleep
        wake_i = 1;
        repeat (2) @(negedge clk);
        wake_i = 0;
        chk("R2 wake not yet seen", gate_drive_en, 1'b1);
        @(negedge clk);
        chk("R4 energise after wake", delay_run, 1'b1);
        repeat (D + 1) @(negedge clk);
        chk("R4 active after wake", core_rst_n, 1'b1);

        // R4 race: sleep and wake in the same cycle
        sleep_i = 1; wake_i = 1;
        repeat (2) @(negedge clk);
        sleep_i = 0; wake_i = 0;
        @(negedge clk);
        chk("R4 race enters sleep", gate_drive_en, 1'b1);
        @(negedge clk);
        chk("R4 race leaves sleep", delay_run, 1'b1);
        chk("R4 race gate released", gate_drive_en, 1'b0);
        repeat (D + 1) @(negedge clk);
        chk("R4 race reaches active", core_rst_n, 1'b1);

        // R9: supply loss beats sleep request
        sleep_i = 1; good_i = 0;
        repeat (3) @(negedge clk);
        chk("R9 back to energise", delay_run, 1'b1);
        chk("R9 not sleeping", gate_drive_en, 1'b0);
        sleep_i = 0; good_i = 1;
        repeat (D + 6) @(negedge clk);
        chk("R9 recovers to active", core_rst_n, 1'b1);

        // constrained random: every level held 2..6 cycles
        for (int seg = 0; seg < 600; seg++) begin
            sleep_i = ($urandom % 3) == 0;
            wake_i  = ($urandom % 3) == 0;
            good_i  = ($urandom % 8) != 0;
            repeat (2 + ($urandom % 5)) @(negedge clk);
        end
        finish_run();
    end
endmodule